// File: doc/BRIEF.md
# Two-Port DMA Transfer and Search Engine

This block is a byte-wide DMA engine for an 8-bit system. It has two ports, A and B, and each one holds a 16-bit address. Either port can act as the source, and each port can point at memory or at I/O space. The engine can copy bytes, compare them against a masked pattern, or copy and compare at the same time. After each byte it steps each port address up or down, or leaves it where it is, according to that port's configuration. It counts bytes against a programmed block length and obeys an external ready line.

The engine drives a simple request/acknowledge bus. The strobes for read, write and memory-or-I/O select are separate. A byte's read always completes before the write of that byte is issued.

The configuration is taken from static inputs. A separate loader owns those inputs and pulses `load_i` to reload the port addresses and clear the counter and the flags. When a run finishes because of a match or because the block ended, the engine can emit a one-cycle interrupt pulse. Its vector can carry the cause.

Top module: `dual_port_dma`

## Requirements
- R1: The engine makes no bus request unless `enable_i` is high and at least one of `cmd_i[0]` (transfer) or `cmd_i[1]` (search) is set.
- R2: When `dir_a2b_i` is 1, port A is the source and port B the destination. When it is 0, B is the source and A the destination.
- R3: In each port configuration byte, bit 3 = 1 selects I/O space (`bus_io_o` high), bit 5 = 1 holds the address, and otherwise bit 4 = 1 increments and bit 4 = 0 decrements the address by one after each byte. Both port addresses step after every counted byte.
- R4: Each byte is read from the source first. It is written to the destination, carrying the value read, only when `cmd_i[0]` is set, and only after the read's acknowledge. A pending request holds its address and strobe until `bus_ack_i`.
- R5: With search enabled, a byte matches when `((data ^ match_val_i) & ~match_mask_i) == 0`. A match sets the sticky `match_o`, and no further byte is fetched while search is enabled and `match_o` is set.
- R6: Outside mode 1 (`mode_i` = 1), ready is active when `rdy_i == rdy_pol_i`, and no service starts while it is inactive. Mode 1 ignores `rdy_i`.
- R7: If ready is inactive when a byte completes (outside mode 1), that byte is still counted, neither address changes, and the burst ends.
- R8: `count_o` increments once per byte. `end_o` is set when the count wraps to zero, or, when `blk_len_i` is neither 0 nor 0xFFFF, once the count reaches `blk_len_i + 1`.
- R9: In mode 0 each service moves one byte and then rechecks `enable_i` before the next. In any nonzero mode the engine keeps going until end-of-block, a match (with search on) or an inactive ready.
- R10: After a service, if `irq_en_i` is set, a match with `irq_ctl_i[0]` set gives code 2. Otherwise end-of-block with `irq_ctl_i[1]` set gives code 4. A nonzero code produces an `irq_o` pulse exactly one cycle long.
- R11: If `irq_ctl_i[5]` is set, `irq_vec_o` is `(irq_base_i & 8'hF9) + code`. Otherwise it is `irq_base_i` unchanged.
- R12: After reset the bus is idle, the count is 0 and both flags are clear. `end_o` and `match_o` stay set until `load_i` clears them. `load_i` also clears the count and loads `start_a_i` and `start_b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Reload addresses, clear count and flags |
| enable_i | input | 1 | Engine enable |
| cmd_i | input | 2 | Bit 0 transfer, bit 1 search |
| dir_a2b_i | input | 1 | 1: A to B, 0: B to A |
| mode_i | input | 2 | 0 single byte, 1 continuous ignoring ready, 2/3 continuous with ready |
| cfg_a_i | input | 8 | Port A configuration |
| cfg_b_i | input | 8 | Port B configuration |
| start_a_i | input | 16 | Port A start address |
| start_b_i | input | 16 | Port B start address |
| blk_len_i | input | 16 | Block length |
| rdy_i | input | 1 | External ready |
| rdy_pol_i | input | 1 | Active level of ready |
| match_val_i | input | 8 | Search pattern |
| match_mask_i | input | 8 | Search mask, 1 = ignore bit |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ctl_i | input | 8 | Bit 0 match irq, bit 1 end irq, bit 5 status in vector |
| irq_base_i | input | 8 | Base vector |
| bus_req_o | output | 1 | Bus request |
| bus_wr_o | output | 1 | 1 write, 0 read |
| bus_io_o | output | 1 | 1 I/O space, 0 memory |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data |
| bus_ack_i | input | 1 | Bus acknowledge |
| addr_a_o | output | 16 | Current port A address |
| addr_b_o | output | 16 | Current port B address |
| count_o | output | 16 | Byte count |
| end_o | output | 1 | End-of-block flag |
| match_o | output | 1 | Match flag |
| irq_o | output | 1 | Interrupt pulse |
| irq_vec_o | output | 8 | Interrupt vector |

## Verification
The bench checks the following corner cases, each against what a faulty design would show.

A block length of 1 must move two bytes. An off-by-one in the length compare would move one byte or three.

A length of 0 must not end the block, so a search has to run until it matches. A design that treats 0 as a literal length would stop at once.

Ready can drop while a byte is in flight. The bench then expects the count to rise while both addresses stay frozen. A design that steps the addresses anyway, or that drops the count, shows up here. The bench also checks that mode 1 runs with ready inactive.

A byte can both match and end the block. Code 2 must win over code 4. The vector must be patched only when the status bit is set, so a design with the priority inverted or with the wrong mask bits gives a wrong vector.

Mode 0 is checked by dropping the enable after the first read. A mode 0 design that keeps looping would move more than one byte.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_UPD, ST_FIN
  } dma_st_e;

  localparam int unsigned CFG_IO_BIT  = 3;
  localparam int unsigned CFG_INC_BIT = 4;
  localparam int unsigned CFG_FIX_BIT = 5;
  localparam int unsigned ICTL_MATCH  = 0;
  localparam int unsigned ICTL_END    = 1;
  localparam int unsigned ICTL_VEC    = 5;
  localparam logic [1:0]  MODE_FREE   = 2'd1;
endpackage

// File: rtl/dma_addr_port.sv
module dma_addr_port #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          fixed_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  addr_o <= '0;
    else if (load_i)              addr_o <= load_val_i;
    else if (step_i && !fixed_i)  addr_o <= inc_i ? addr_o + 1'b1 : addr_o - 1'b1;
  end
endmodule

// File: rtl/dma_blk_cnt.sv
module dma_blk_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          end_o
);
  logic [CW-1:0] nxt;
  logic          limited;

  assign nxt     = cnt_o + 1'b1;
  assign limited = (len_i != '0) && (len_i != '1);
  // len_i + 1 cannot overflow when limited
  assign last_o  = (nxt == '0) || (limited && (nxt >= len_i + 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      end_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      end_o <= 1'b0;
    end else if (inc_i) begin
      cnt_o <= nxt;
      if (last_o) end_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_irq_vec.sv
module dma_irq_vec
  import dma_pkg::*;
#(
  parameter int unsigned VW = 8
) (
  input  logic          irq_en_i,
  input  logic [7:0]    irq_ctl_i,
  input  logic [VW-1:0] base_i,
  input  logic          match_i,
  input  logic          end_i,
  output logic          fire_o,
  output logic [VW-1:0] vec_o
);
  localparam logic [VW-1:0] CAUSE_MASK = VW'(6);
  logic [VW-1:0] code;

  always_comb begin
    code = '0;
    if (irq_en_i) begin
      if (match_i && irq_ctl_i[ICTL_MATCH])   code = VW'(2);
      else if (end_i && irq_ctl_i[ICTL_END])  code = VW'(4);
    end
    fire_o = (code != '0);
    vec_o  = irq_ctl_i[ICTL_VEC] ? ((base_i & ~CAUSE_MASK) + code) : base_i;
  end
endmodule

// File: rtl/dual_port_dma.sv
module dual_port_dma
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          enable_i,
  input  logic [1:0]    cmd_i,
  input  logic          dir_a2b_i,
  input  logic [1:0]    mode_i,
  input  logic [7:0]    cfg_a_i,
  input  logic [7:0]    cfg_b_i,
  input  logic [AW-1:0] start_a_i,
  input  logic [AW-1:0] start_b_i,
  input  logic [CW-1:0] blk_len_i,
  input  logic          rdy_i,
  input  logic          rdy_pol_i,
  input  logic [DW-1:0] match_val_i,
  input  logic [DW-1:0] match_mask_i,
  input  logic          irq_en_i,
  input  logic [7:0]    irq_ctl_i,
  input  logic [7:0]    irq_base_i,
  output logic          bus_req_o,
  output logic          bus_wr_o,
  output logic          bus_io_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [CW-1:0] count_o,
  output logic          end_o,
  output logic          match_o,
  output logic          irq_o,
  output logic [7:0]    irq_vec_o
);
  dma_st_e       state_q, state_d;
  logic [DW-1:0] data_q;
  logic          match_q;
  logic          rdy_ok, can_start, hit, upd, step, last, more;
  logic          xfer, srch, irq_fire;
  logic [7:0]    src_cfg, dst_cfg;

  assign xfer    = cmd_i[0];
  assign srch    = cmd_i[1];
  assign src_cfg = dir_a2b_i ? cfg_a_i : cfg_b_i;
  assign dst_cfg = dir_a2b_i ? cfg_b_i : cfg_a_i;
  assign rdy_ok  = (mode_i == MODE_FREE) || (rdy_i == rdy_pol_i);
  assign hit     = srch && (((data_q ^ match_val_i) & ~match_mask_i) == '0);
  assign upd     = (state_q == ST_UPD);
  assign step    = upd && rdy_ok;

  assign can_start = enable_i && (cmd_i != 2'b00) && !end_o &&
                     !(srch && match_q) && rdy_ok;
  assign more      = (mode_i != 2'd0) && !last && !hit && !(srch && match_q) && rdy_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (can_start) state_d = ST_RD;
      ST_RD:   if (bus_ack_i) state_d = xfer ? ST_WR : ST_UPD;
      ST_WR:   if (bus_ack_i) state_d = ST_UPD;
      ST_UPD:  state_d = more ? ST_RD : ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (load_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      match_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD && bus_ack_i) data_q <= bus_rdata_i;
      if (load_i)          match_q <= 1'b0;
      else if (upd && hit) match_q <= 1'b1;
    end
  end

  dma_addr_port #(.AW(AW)) u_port_a (
    .clk_i, .rst_ni, .load_i, .load_val_i(start_a_i), .step_i(step),
    .fixed_i(cfg_a_i[CFG_FIX_BIT]), .inc_i(cfg_a_i[CFG_INC_BIT]), .addr_o(addr_a_o)
  );

  dma_addr_port #(.AW(AW)) u_port_b (
    .clk_i, .rst_ni, .load_i, .load_val_i(start_b_i), .step_i(step),
    .fixed_i(cfg_b_i[CFG_FIX_BIT]), .inc_i(cfg_b_i[CFG_INC_BIT]), .addr_o(addr_b_o)
  );

  dma_blk_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .clr_i(load_i), .inc_i(upd), .len_i(blk_len_i),
    .cnt_o(count_o), .last_o(last), .end_o(end_o)
  );

  dma_irq_vec #(.VW(8)) u_vec (
    .irq_en_i, .irq_ctl_i, .base_i(irq_base_i), .match_i(match_q),
    .end_i(end_o), .fire_o(irq_fire), .vec_o(irq_vec_o)
  );

  assign match_o     = match_q;
  assign irq_o       = (state_q == ST_FIN) && irq_fire;
  assign bus_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_wr_o    = (state_q == ST_WR);
  assign bus_io_o    = bus_wr_o ? dst_cfg[CFG_IO_BIT] : src_cfg[CFG_IO_BIT];
  assign bus_wdata_o = data_q;
  always_comb begin
    if (bus_wr_o) bus_addr_o = dir_a2b_i ? addr_b_o : addr_a_o;
    else          bus_addr_o = dir_a2b_i ? addr_a_o : addr_b_o;
  end
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [1:0]    cmd_i,
  input logic          bus_req_o,
  input logic          bus_wr_o,
  input logic          bus_ack_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [CW-1:0] count_o,
  input logic          end_o,
  input logic          match_o,
  input logic          irq_o
);
  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R4
  wr_needs_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_wr_o) |-> cmd_i[0]);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !load_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_wr_o)));

  // R12
  end_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !load_i) |=> end_o);

  // R12
  match_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !load_i) |=> match_o);

  // R8
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((count_o == $past(count_o)) || (count_o == CW'($past(count_o) + 1'b1))));
endmodule

bind dual_port_dma dma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .cmd_i(cmd_i),
  .bus_req_o(bus_req_o), .bus_wr_o(bus_wr_o), .bus_ack_i(bus_ack_i),
  .bus_addr_o(bus_addr_o), .count_o(count_o), .end_o(end_o),
  .match_o(match_o), .irq_o(irq_o)
);

// File: tb/dual_port_dma_tb.sv
module dual_port_dma_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, enable_i = 1'b0, dir_a2b_i = 1'b1;
  logic [1:0]  cmd_i = 2'd1, mode_i = 2'd1;
  logic [7:0]  cfg_a_i = '0, cfg_b_i = '0;
  logic [15:0] start_a_i = '0, start_b_i = '0, blk_len_i = 16'd1;
  logic        rdy_i = 1'b1, rdy_pol_i = 1'b1;
  logic [7:0]  match_val_i = '0, match_mask_i = '0;
  logic        irq_en_i = 1'b0;
  logic [7:0]  irq_ctl_i = '0, irq_base_i = '0;
  logic        bus_req_o, bus_wr_o, bus_io_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic [7:0]  bus_rdata_i = '0;
  logic        bus_ack_i = 1'b0;
  logic [15:0] addr_a_o, addr_b_o, count_o;
  logic        end_o, match_o, irq_o;
  logic [7:0]  irq_vec_o;

  always #2 clk_i = ~clk_i;

  dual_port_dma u_dut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [256];
  logic [7:0] iom [256];
  logic [7:0] xmem [256];
  logic [7:0] xiom [256];
  int  irq_cnt = 0;
  logic [7:0] irq_last = '0;
  int  rd_cnt = 0;
  int  wait_n = 0;
  bit  drop_rdy = 0, drop_en = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
  end

  // bus responder and irq monitor
  always @(negedge clk_i) begin
    if (irq_o) begin irq_cnt++; irq_last = irq_vec_o; end
    if (!rst_ni) bus_ack_i = 1'b0;
    else if (bus_ack_i) bus_ack_i = 1'b0;
    else if (bus_req_o) begin
      if (wait_n > 0) wait_n--;
      else begin
        bus_ack_i = 1'b1;
        wait_n = $urandom_range(0, 2);
        if (!bus_wr_o) begin
          rd_cnt++;
          bus_rdata_i = bus_io_o ? iom[bus_addr_o[7:0]] : mem[bus_addr_o[7:0]];
          if (drop_rdy) begin rdy_i = ~rdy_pol_i; drop_rdy = 0; end
          if (drop_en) begin enable_i = 1'b0; drop_en = 0; end
        end else if (bus_io_o) iom[bus_addr_o[7:0]] = bus_wdata_o;
        else mem[bus_addr_o[7:0]] = bus_wdata_o;
      end
    end
  end

  // expected results
  logic [15:0] e_a, e_b, e_cnt;
  bit e_end, e_match;
  int e_irq;
  logic [7:0] e_vec;

  function automatic logic [15:0] stp(input logic [15:0] a, input logic [7:0] c);
    if (c[5]) return a;
    return c[4] ? a + 16'd1 : a - 16'd1;
  endfunction

  task automatic ref_run();
    logic [7:0] d, code;
    logic [15:0] sa, da;
    logic [7:0] sc, dc;
    for (int i = 0; i < 256; i++) begin xmem[i] = mem[i]; xiom[i] = iom[i]; end
    e_a = start_a_i; e_b = start_b_i; e_cnt = 0; e_end = 0; e_match = 0;
    while (!e_end && !(cmd_i[1] && e_match) && cmd_i != 0) begin
      sa = dir_a2b_i ? e_a : e_b;   da = dir_a2b_i ? e_b : e_a;
      sc = dir_a2b_i ? cfg_a_i : cfg_b_i; dc = dir_a2b_i ? cfg_b_i : cfg_a_i;
      d = sc[3] ? xiom[sa[7:0]] : xmem[sa[7:0]];
      if (cmd_i[0]) begin
        if (dc[3]) xiom[da[7:0]] = d; else xmem[da[7:0]] = d;
      end
      if (cmd_i[1] && (((d ^ match_val_i) & ~match_mask_i) == 0)) e_match = 1;
      e_a = stp(e_a, cfg_a_i); e_b = stp(e_b, cfg_b_i);
      e_cnt++;
      if (e_cnt == 0 || (blk_len_i != 0 && blk_len_i != 16'hFFFF &&
                         {16'd0, e_cnt} >= {16'd0, blk_len_i} + 32'd1)) e_end = 1;
    end
    code = 0;
    if (irq_en_i) begin
      if (e_match && irq_ctl_i[0]) code = 2;
      else if (e_end && irq_ctl_i[1]) code = 4;
    end
    e_irq = (code != 0) ? 1 : 0;
    e_vec = irq_ctl_i[5] ? ((irq_base_i & 8'hF9) + code) : irq_base_i;
  endtask

  task automatic do_load();
    @(negedge clk_i); load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    irq_cnt = 0; rd_cnt = 0;
  endtask

  task automatic run_block();
    do_load();
    enable_i = 1'b1;
    for (int i = 0; i < 3000 && !(end_o || match_o); i++) @(negedge clk_i);
    repeat (8) @(negedge clk_i);
    enable_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic compare(input string tag);
    bit ok = 1;
    for (int i = 0; i < 256; i++) if (mem[i] !== xmem[i] || iom[i] !== xiom[i]) ok = 0;
    chk(ok, {tag, " R2 R4 data"}, ok, 1);
    chk(addr_a_o == e_a && addr_b_o == e_b, {tag, " R3 addr"}, {addr_a_o, addr_b_o}, {e_a, e_b});
    chk(count_o == e_cnt && end_o == e_end, {tag, " R8 count/end"}, {end_o, count_o}, {e_end, e_cnt});
    chk(match_o == e_match, {tag, " R5 match"}, match_o, e_match);
    chk(irq_cnt == e_irq, {tag, " R10 irq count"}, irq_cnt, e_irq);
    if (e_irq != 0) chk(irq_last == e_vec, {tag, " R11 vector"}, irq_last, e_vec);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom); iom[i] = 8'($urandom);
    end
  endtask

  task automatic rand_cfg();
    cmd_i = 2'($urandom_range(1, 3));
    dir_a2b_i = 1'($urandom);
    mode_i = 2'($urandom_range(0, 2));
    cfg_a_i = 8'($urandom) & 8'h38;
    cfg_b_i = 8'($urandom) & 8'h38;
    start_a_i = 16'($urandom); start_b_i = 16'($urandom);
    blk_len_i = 16'($urandom_range(1, 24));
    rdy_pol_i = 1'($urandom); rdy_i = rdy_pol_i;
    match_val_i = 8'($urandom);
    match_mask_i = 8'($urandom) | 8'hC3;
    irq_en_i = 1'($urandom_range(0, 3) != 0);
    irq_ctl_i = 8'($urandom) & 8'h23;
    irq_base_i = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5EED_0D1A));
    fill_mem();
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(!bus_req_o && count_o == 0 && !end_o && !match_o && !irq_o, "R12 reset",
        {bus_req_o, end_o, match_o, count_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 no command: idle with enable on
    cmd_i = 2'd0; do_load(); enable_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(rd_cnt == 0 && count_o == 0, "R1 idle cmd=0", rd_cnt, 0);
    enable_i = 1'b0;

    // R6 ready inactive blocks start in mode 2
    cmd_i = 2'd1; mode_i = 2'd2; rdy_pol_i = 1'b0; rdy_i = 1'b1;
    blk_len_i = 16'd3; cfg_a_i = 8'h10; cfg_b_i = 8'h10; dir_a2b_i = 1;
    do_load(); enable_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(rd_cnt == 0 && count_o == 0, "R6 ready inactive", rd_cnt, 0);
    enable_i = 1'b0;

    // R6 mode 1 ignores ready
    mode_i = 2'd1; start_a_i = 16'h0010; start_b_i = 16'h0080;
    ref_run(); run_block(); compare("R6 mode1");

    // R7 ready drops during first byte
    mode_i = 2'd2; rdy_i = rdy_pol_i; blk_len_i = 16'd5;
    start_a_i = 16'h0020; start_b_i = 16'h0090;
    do_load(); drop_rdy = 1; enable_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(count_o == 1, "R7 counted", count_o, 1);
    chk(addr_a_o == 16'h0020 && addr_b_o == 16'h0090, "R7 addr frozen",
        {addr_a_o, addr_b_o}, {16'h0020, 16'h0090});
    chk(rd_cnt == 1 && !end_o, "R7 burst ends", rd_cnt, 1);
    enable_i = 1'b0; rdy_i = rdy_pol_i;

    // R8 length 1 moves two bytes
    mode_i = 2'd1; blk_len_i = 16'd1;
    ref_run(); run_block(); compare("R8 len1");
    chk(count_o == 2, "R8 len1 two bytes", count_o, 2);

    // R8 R5 length 0 runs until match on third byte
    cmd_i = 2'd3; blk_len_i = 16'd0; cfg_a_i = 8'h10; start_a_i = 16'h0040;
    match_val_i = mem[8'h42]; match_mask_i = 8'h00;
    mem[8'h40] = match_val_i ^ 8'h01; mem[8'h41] = match_val_i ^ 8'h80;
    irq_en_i = 1; irq_ctl_i = 8'h23; irq_base_i = 8'hFF;
    ref_run(); run_block(); compare("R5 len0 search");
    chk(count_o == 3 && match_o && !end_o, "R8 len0 no limit", count_o, 3);

    // R10 R11 match and end on same byte: code 2 wins
    blk_len_i = 16'd2; irq_base_i = 8'h86;
    ref_run(); run_block(); compare("R10 prio");
    chk(irq_last == 8'h82, "R10 code2 vector", irq_last, 8'h82);

    // R11 status bit clear: base unchanged
    cmd_i = 2'd1; blk_len_i = 16'd3; irq_ctl_i = 8'h02; irq_base_i = 8'h5E;
    ref_run(); run_block(); compare("R11 plain");
    chk(irq_last == 8'h5E, "R11 base only", irq_last, 8'h5E);

    // R10 interrupt disabled
    irq_en_i = 0; irq_ctl_i = 8'h23;
    ref_run(); run_block();
    chk(irq_cnt == 0, "R10 irq disabled", irq_cnt, 0);

    // R9 mode 0 rechecks enable after one byte; mode 1 does not
    irq_en_i = 1; blk_len_i = 16'd6; mode_i = 2'd0;
    do_load(); drop_en = 1; enable_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(count_o == 1, "R9 mode0 single", count_o, 1);
    mode_i = 2'd1;
    do_load(); drop_en = 1; enable_i = 1'b1;
    repeat (80) @(negedge clk_i);
    chk(count_o == 7 && end_o, "R9 mode1 loops", count_o, 7);
    enable_i = 1'b0;

    // R12 load clears flags and count
    do_load();
    chk(!end_o && !match_o && count_o == 0 && addr_a_o == start_a_i, "R12 load clears",
        {end_o, match_o, count_o}, 0);

    // random runs covering R2 R3 R4 R5 R8 R9 R10 R11
    for (int k = 0; k < 40; k++) begin
      fill_mem(); rand_cfg();
      ref_run(); run_block(); compare($sformatf("rnd%0d", k));
    end

    finish_run();
  end
endmodule